// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command front end of a 16-bit parallel NOR flash that uses the classic unlock-cycle command set. It watches each host write (word address plus data word) and steps through unlock, setup and command states. From these it decides which operation to launch: word program, chip erase, sector erase, entry to and exit from unlock bypass, the identifier read, the query table read, and return to the previous read mode. It also handles suspend and resume of a running erase. Operations go to a separate embedded-operation engine as single-cycle start pulses that carry the target address and data.

A read-view select tells the data path what a host read returns: array contents, identifier words, query-table words, or status. The identifier word for the current read address is produced here. The query-table contents and the array are outside the block. The engine reports three things back: that it is busy, whether the busy operation is an erase, and whether the erase accept window is still open.

Top module: `nor_cmd_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_sel` is 0 (array), `bypass_on` and `suspended` are 0, and all go pulses are 0. Reset also clears bypass mode partway through use.
- R2: The identifier view is entered by three writes: 0xAA at address 0x555, 0x55 at 0x2AA, then 0x90 at 0x555. After this `rd_sel` is 1. `id_word` is 0xBF when `rd_addr[0]`=0 and 0x236D when `rd_addr[0]`=1. Only the low 11 address bits are compared, so 0x5555 and 0x2AAA act as 0x555 and 0x2AA.
- R3: Writing 0x98 at address 0x55 from idle sets `rd_sel` to 2 (query). Writing 0xF0 at any address returns to the previous view: to 1 if the query view was entered from the identifier view, and otherwise to 0. 0xF0 from the identifier view gives 0.
- R4: Program is the unlock pair, then 0xA0 at 0x555, then a data write. One cycle after the data write, `prog_go` is high for one cycle, with `prog_addr`/`prog_data` equal to that write's address and data.
- R5: The erase sequence is the unlock pair, 0x80 at 0x555, and a second unlock pair. A final 0x10 at 0x555 pulses `chip_go`. A final 0x30 at any address pulses `sect_go`, with `sect_addr` set to that address.
- R6: The unlock pair followed by 0x20 at 0x555 sets `bypass_on`. While it is set, 0xA0 at any address followed by a data write pulses `prog_go`. A write of 0x00 clears `bypass_on`, and after that an 0xA0 and data write with no unlock pair starts nothing.
- R7: A write that does not match the next expected cycle of a sequence returns the decoder to idle and starts no operation.
- R8: While `eng_busy` is high and `suspended` is low, command writes start nothing. The exceptions are suspend and window sector writes. The sequence state returns to idle.
- R9: 0xB0 at any address while `eng_busy` and `eng_erase` are high pulses `susp_go` and sets `suspended`. While suspended, other writes are ignored, and 0x30 at any address pulses `resume_go` and clears `suspended`.
- R10: While `eng_busy`, `eng_erase` and `erase_window` are high, 0x30 at any address pulses `sect_go` with that address. With the window closed, the same write pulses nothing.
- R11: Only data bits 7:0 are compared against command codes. For example, 0x12AA acts as 0xAA.
- R12: `rd_sel` is 3 (status) whenever `eng_busy` is high and `suspended` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data word of the write |
| rd_addr | input | ADDR_W | Word address of the current host read |
| eng_busy | input | 1 | Engine is running an operation |
| eng_erase | input | 1 | The running operation is an erase |
| erase_window | input | 1 | Extra sector addresses are still accepted |
| rd_sel | output | 2 | Read view: 0 array, 1 identifier, 2 query, 3 status |
| id_word | output | DATA_W | Identifier word for `rd_addr` |
| bypass_on | output | 1 | Unlock bypass mode active |
| suspended | output | 1 | Erase is suspended |
| prog_go | output | 1 | Program start pulse |
| prog_addr | output | ADDR_W | Program word address |
| prog_data | output | DATA_W | Program data |
| sect_go | output | 1 | Sector erase start or add pulse |
| sect_addr | output | ADDR_W | Sector address |
| chip_go | output | 1 | Chip erase start pulse |
| susp_go | output | 1 | Erase suspend request pulse |
| resume_go | output | 1 | Erase resume request pulse |

## Verification
The properties assume that the engine raises `eng_busy` only after a start pulse and never while a program sequence is still being collected. They also assume that `eng_erase` and `erase_window` are only high together with `eng_busy`. The stimulus keeps to these assumptions: it changes the engine inputs only between completed writes, and it raises the window only with busy and erase already high. Writes are one-cycle strobes separated by an idle cycle, which is the only write shape the decoder is specified for.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [15:0] ADDR_UNLK0 = 16'h0555;
    localparam logic [15:0] ADDR_UNLK1 = 16'h02AA;
    localparam logic [15:0] ADDR_QRY   = 16'h0055;

    localparam logic [7:0] C_UNLK0   = 8'hAA;
    localparam logic [7:0] C_UNLK1   = 8'h55;
    localparam logic [7:0] C_IDREAD  = 8'h90;
    localparam logic [7:0] C_QUERY   = 8'h98;
    localparam logic [7:0] C_BACK    = 8'hF0;
    localparam logic [7:0] C_PROG    = 8'hA0;
    localparam logic [7:0] C_ESETUP  = 8'h80;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] C_SECT    = 8'h30;
    localparam logic [7:0] C_BYP_ON  = 8'h20;
    localparam logic [7:0] C_BYP_OFF = 8'h00;
    localparam logic [7:0] C_SUSP    = 8'hB0;

    typedef enum logic [1:0] {
        VIEW_ARRAY  = 2'd0,
        VIEW_ID     = 2'd1,
        VIEW_QUERY  = 2'd2,
        VIEW_STATUS = 2'd3
    } view_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_CMD, SQ_PGM, SQ_EUNL0, SQ_EUNL1, SQ_ECMD
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_PROG, OP_SECT, OP_CHIP
    } op_e;

    typedef struct packed {
        logic       at_u0;
        logic       at_u1;
        logic       at_qry;
        logic [7:0] code;
    } cmd_hit_t;

    typedef struct packed {
        logic id_in;
        logic qry_in;
        logic back;
        logic op;
    } mode_ev_t;

endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 11
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_hit_t          hit
);
    localparam logic [CMP_W-1:0] U0 = CMP_W'(ADDR_UNLK0);
    localparam logic [CMP_W-1:0] U1 = CMP_W'(ADDR_UNLK1);
    localparam logic [CMP_W-1:0] QA = CMP_W'(ADDR_QRY);

    logic [CMP_W-1:0] low_a;

    always_comb begin
        low_a      = wr_addr[CMP_W-1:0];
        hit.at_u0  = (low_a == U0);
        hit.at_u1  = (low_a == U1);
        hit.at_qry = (low_a == QA);
        hit.code   = wr_data[7:0];
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              seq_en,
    input  cmd_hit_t          hit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_ev_t          ev,
    output logic              bypass_on,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              sect_go,
    output logic [ADDR_W-1:0] sect_addr,
    output logic              chip_go
);
    seq_state_e st, st_n;
    logic       byp_n;
    op_e        op_n;

    always_comb begin
        st_n  = st;
        byp_n = bypass_on;
        op_n  = OP_NONE;
        ev    = '0;
        if (!seq_en) begin
            st_n = SQ_IDLE;
        end else if (wr_en) begin
            st_n = SQ_IDLE;
            if (st != SQ_PGM && hit.code == C_BACK) begin
                ev.back = 1'b1;
            end else begin
                case (st)
                    SQ_IDLE: begin
                        if (bypass_on) begin
                            if (hit.code == C_PROG)         st_n  = SQ_PGM;
                            else if (hit.code == C_BYP_OFF) byp_n = 1'b0;
                        end else if (hit.code == C_UNLK0 && hit.at_u0) begin
                            st_n = SQ_UNL1;
                        end else if (hit.code == C_QUERY && hit.at_qry) begin
                            ev.qry_in = 1'b1;
                        end
                    end
                    SQ_UNL1: if (hit.code == C_UNLK1 && hit.at_u1) st_n = SQ_CMD;
                    SQ_CMD: begin
                        if (hit.at_u0) begin
                            case (hit.code)
                                C_IDREAD: ev.id_in = 1'b1;
                                C_PROG:   st_n     = SQ_PGM;
                                C_ESETUP: st_n     = SQ_EUNL0;
                                C_BYP_ON: byp_n    = 1'b1;
                                default:  st_n     = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PGM:   op_n = OP_PROG;
                    SQ_EUNL0: if (hit.code == C_UNLK0 && hit.at_u0) st_n = SQ_EUNL1;
                    SQ_EUNL1: if (hit.code == C_UNLK1 && hit.at_u1) st_n = SQ_ECMD;
                    SQ_ECMD: begin
                        if (hit.code == C_CHIP && hit.at_u0) op_n = OP_CHIP;
                        else if (hit.code == C_SECT)         op_n = OP_SECT;
                    end
                    default: st_n = SQ_IDLE;
                endcase
            end
        end
        ev.op = (op_n != OP_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            bypass_on <= 1'b0;
            prog_go   <= 1'b0;
            sect_go   <= 1'b0;
            chip_go   <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
            sect_addr <= '0;
        end else begin
            st        <= st_n;
            bypass_on <= byp_n;
            prog_go   <= (op_n == OP_PROG);
            sect_go   <= (op_n == OP_SECT);
            chip_go   <= (op_n == OP_CHIP);
            if (op_n == OP_PROG) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (op_n == OP_SECT) sect_addr <= wr_addr;
        end
    end
endmodule

// File: rtl/nor_erase_ctl.sv
module nor_erase_ctl
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        code,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              eng_busy,
    input  logic              eng_erase,
    input  logic              erase_window,
    output logic              suspended,
    output logic              susp_go,
    output logic              resume_go,
    output logic              win_go,
    output logic [ADDR_W-1:0] win_addr
);
    logic erasing;
    logic do_susp, do_res, do_win;

    always_comb begin
        erasing = eng_busy && eng_erase;
        do_res  = wr_en && suspended && (code == C_SECT);
        do_susp = wr_en && !suspended && erasing && (code == C_SUSP);
        do_win  = wr_en && !suspended && erasing && erase_window && (code == C_SECT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            suspended <= 1'b0;
            susp_go   <= 1'b0;
            resume_go <= 1'b0;
            win_go    <= 1'b0;
            win_addr  <= '0;
        end else begin
            susp_go   <= do_susp;
            resume_go <= do_res;
            win_go    <= do_win;
            if (do_susp)     suspended <= 1'b1;
            else if (do_res) suspended <= 1'b0;
            if (do_win) win_addr <= wr_addr;
        end
    end
endmodule

// File: rtl/nor_read_mode.sv
module nor_read_mode
    import nor_cmd_pkg::*;
#(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] MFR_ID = 16'h00BF,
    parameter logic [DATA_W-1:0] DEV_ID = 16'h236D
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_ev_t          ev,
    input  logic              eng_busy,
    input  logic              suspended,
    input  logic              rd_lsb,
    output logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] id_word
);
    view_e view_q;
    logic  from_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            view_q  <= VIEW_ARRAY;
            from_id <= 1'b0;
        end else if (ev.op) begin
            view_q  <= VIEW_ARRAY;
            from_id <= 1'b0;
        end else if (ev.id_in) begin
            view_q  <= VIEW_ID;
            from_id <= 1'b0;
        end else if (ev.qry_in) begin
            from_id <= (view_q == VIEW_ID) || (view_q == VIEW_QUERY && from_id);
            view_q  <= VIEW_QUERY;
        end else if (ev.back) begin
            view_q  <= (view_q == VIEW_QUERY && from_id) ? VIEW_ID : VIEW_ARRAY;
            from_id <= 1'b0;
        end
    end

    always_comb begin
        rd_sel  = (eng_busy && !suspended) ? VIEW_STATUS : view_q;
        id_word = rd_lsb ? DEV_ID : MFR_ID;
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int                ADDR_W = 22,
    parameter int                DATA_W = 16,
    parameter int                CMP_W  = 11,
    parameter logic [DATA_W-1:0] MFR_ID = 16'h00BF,
    parameter logic [DATA_W-1:0] DEV_ID = 16'h236D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              eng_busy,
    input  logic              eng_erase,
    input  logic              erase_window,
    output logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] id_word,
    output logic              bypass_on,
    output logic              suspended,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              sect_go,
    output logic [ADDR_W-1:0] sect_addr,
    output logic              chip_go,
    output logic              susp_go,
    output logic              resume_go
);
    cmd_hit_t          hit;
    mode_ev_t          ev;
    logic              seq_en;
    logic              seq_sect_go, win_go;
    logic [ADDR_W-1:0] seq_sect_addr, win_addr;

    assign seq_en    = !eng_busy && !suspended;
    assign sect_go   = seq_sect_go | win_go;
    assign sect_addr = win_go ? win_addr : seq_sect_addr;

    nor_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) match_i (
        .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit)
    );

    nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .seq_en(seq_en), .hit(hit),
        .wr_addr(wr_addr), .wr_data(wr_data), .ev(ev), .bypass_on(bypass_on),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .sect_go(seq_sect_go), .sect_addr(seq_sect_addr), .chip_go(chip_go)
    );

    nor_erase_ctl #(.ADDR_W(ADDR_W)) erase_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .code(hit.code), .wr_addr(wr_addr),
        .eng_busy(eng_busy), .eng_erase(eng_erase), .erase_window(erase_window),
        .suspended(suspended), .susp_go(susp_go), .resume_go(resume_go),
        .win_go(win_go), .win_addr(win_addr)
    );

    nor_read_mode #(.DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) view_i (
        .clk(clk), .rst(rst), .ev(ev), .eng_busy(eng_busy), .suspended(suspended),
        .rd_lsb(rd_addr[0]), .rd_sel(rd_sel), .id_word(id_word)
    );
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              eng_busy,
    input logic [1:0]        rd_sel,
    input logic              bypass_on,
    input logic              suspended,
    input logic              prog_go,
    input logic              sect_go,
    input logic              chip_go,
    input logic              susp_go,
    input logic              resume_go
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_sel == 2'd0 || eng_busy) && !bypass_on && !suspended && !prog_go && !chip_go);

    // R4
    prog_single_chk: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> !prog_go);

    // R5
    starts_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_go, sect_go, chip_go, susp_go, resume_go}));

    // R6
    bypass_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_on) |-> $past(wr_en) && ($past(wr_data[7:0]) == 8'h20));

    // R8
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !suspended) |=> !prog_go && !chip_go);

    // R9
    suspend_sets_chk: assert property (@(posedge clk) disable iff (rst)
        susp_go |-> suspended);

    // R9
    resume_clears_chk: assert property (@(posedge clk) disable iff (rst)
        resume_go |-> !suspended);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eng_busy(eng_busy),
    .rd_sel(rd_sel), .bypass_on(bypass_on), .suspended(suspended),
    .prog_go(prog_go), .sect_go(sect_go), .chip_go(chip_go),
    .susp_go(susp_go), .resume_go(resume_go)
);

// File: tb/nor_cmd_decoder_tb_top.sv
module nor_cmd_decoder_tb_top;
    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          eng_busy = 1'b0, eng_erase = 1'b0, erase_window = 1'b0;
    logic [1:0]    rd_sel;
    logic [DW-1:0] id_word, prog_data;
    logic          bypass_on, suspended, prog_go, sect_go, chip_go, susp_go, resume_go;
    logic [AW-1:0] prog_addr, sect_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nor_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .eng_busy(eng_busy), .eng_erase(eng_erase),
        .erase_window(erase_window), .rd_sel(rd_sel), .id_word(id_word),
        .bypass_on(bypass_on), .suspended(suspended), .prog_go(prog_go),
        .prog_addr(prog_addr), .prog_data(prog_data), .sect_go(sect_go),
        .sect_addr(sect_addr), .chip_go(chip_go), .susp_go(susp_go),
        .resume_go(resume_go)
    );

    // pl = {prog_go, sect_go, chip_go}
    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [1:0]    sel;
        logic [2:0]    pl;
        logic          byp;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VECS [NV] = '{
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R2 unlock
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0090, 2'd1, 3'b000, 1'b0},  // R2 id view
        '{22'h000, 16'h00F0, 2'd0, 3'b000, 1'b0},  // R3 back to array
        '{22'h055, 16'h0098, 2'd2, 3'b000, 1'b0},  // R3 query
        '{22'h123, 16'h00F0, 2'd0, 3'b000, 1'b0},  // R3
        '{22'h5555, 16'h00AA, 2'd0, 3'b000, 1'b0}, // R2 high bits ignored
        '{22'h2AAA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h5555, 16'h0090, 2'd1, 3'b000, 1'b0},
        '{22'h055, 16'h0098, 2'd2, 3'b000, 1'b0},  // R3 query from id
        '{22'h000, 16'h00F0, 2'd1, 3'b000, 1'b0},  // R3 returns to id
        '{22'h000, 16'h00F0, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R4 program
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00A0, 2'd0, 3'b000, 1'b0},
        '{22'h1234, 16'hBEEF, 2'd0, 3'b100, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R7 bad second cycle
        '{22'h2AA, 16'h0056, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00A0, 2'd0, 3'b000, 1'b0},
        '{22'h0777, 16'h1111, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R5 chip erase
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0080, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0010, 2'd0, 3'b001, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R5 sector erase
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0080, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h3F0000, 16'h0030, 2'd0, 3'b010, 1'b0},
        '{22'h555, 16'h12AA, 2'd0, 3'b000, 1'b0},  // R11 upper data bits
        '{22'h2AA, 16'hFF55, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'hA590, 2'd1, 3'b000, 1'b0},
        '{22'h000, 16'h00F0, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R6 bypass entry
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0020, 2'd0, 3'b000, 1'b1},
        '{22'h0ABC, 16'h00A0, 2'd0, 3'b000, 1'b1}, // R6 A0 any address
        '{22'h0ABC, 16'h4321, 2'd0, 3'b100, 1'b1},
        '{22'h000, 16'h0000, 2'd0, 3'b000, 1'b0},  // R6 leave bypass
        '{22'h555, 16'h00A0, 2'd0, 3'b000, 1'b0},
        '{22'h0100, 16'h5A5A, 2'd0, 3'b000, 1'b0}, // R6 no program now
        '{22'h555, 16'h00AA, 2'd0, 3'b000, 1'b0},  // R7 bad erase unlock
        '{22'h2AA, 16'h0055, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0080, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h00AB, 2'd0, 3'b000, 1'b0},
        '{22'h555, 16'h0010, 2'd0, 3'b000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write strobe; returns at the negedge after the sampling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock_pair();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_sel in reset", rd_sel, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_sel", rd_sel, 0);
        chk("R1 bypass/suspend/pulses",
            {bypass_on, suspended, prog_go, sect_go, chip_go, susp_go, resume_go}, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].a, VECS[i].d);
            chk($sformatf("vec%0d rd_sel", i), rd_sel, VECS[i].sel);
            chk($sformatf("vec%0d pulses", i), {prog_go, sect_go, chip_go}, VECS[i].pl);
            chk($sformatf("vec%0d bypass", i), bypass_on, VECS[i].byp);
        end

        // R2 identifier words
        unlock_pair(); wr(22'h555, 16'h0090);
        rd_addr = 22'h0; #1;
        chk("R2 manufacturer id", id_word, 16'h00BF);
        rd_addr = 22'h1; #1;
        chk("R2 device id", id_word, 16'h236D);
        wr(22'h0, 16'h00F0);

        // R4 program address and data
        unlock_pair(); wr(22'h555, 16'h00A0); wr(22'h1ABCD, 16'hC3C3);
        chk("R4 prog_go", prog_go, 1);
        chk("R4 prog_addr", prog_addr, 22'h1ABCD);
        chk("R4 prog_data", prog_data, 16'hC3C3);
        @(negedge clk);
        chk("R4 single pulse", prog_go, 0);

        // R5 sector address
        unlock_pair(); wr(22'h555, 16'h0080); unlock_pair(); wr(22'h2F123, 16'h0030);
        chk("R5 sect_addr", sect_addr, 22'h2F123);

        // R8 busy blocks commands; R12 status view
        eng_busy = 1'b1;
        @(negedge clk);
        chk("R12 status view", rd_sel, 3);
        wr(22'h555, 16'h00AA); chk("R8 no op", prog_go, 0);
        wr(22'h2AA, 16'h0055);
        wr(22'h555, 16'h00A0);
        wr(22'h0200, 16'h7777); chk("R8 program ignored", prog_go, 0);
        wr(22'h0, 16'h00B0); chk("R8 suspend needs erase", {susp_go, suspended}, 0);
        eng_busy = 1'b0;
        wr(22'h0300, 16'h8888); chk("R8 state back to idle", prog_go, 0);
        chk("R12 array when idle", rd_sel, 0);

        // R9 suspend and resume
        eng_busy = 1'b1; eng_erase = 1'b1;
        wr(22'h777, 16'h00B0);
        chk("R9 susp_go", susp_go, 1);
        chk("R9 suspended", suspended, 1);
        chk("R9 view while suspended", rd_sel, 0);
        unlock_pair(); wr(22'h555, 16'h0020);
        chk("R9 writes ignored while suspended", bypass_on, 0);
        wr(22'h0, 16'h0030);
        chk("R9 resume_go", resume_go, 1);
        chk("R9 cleared", suspended, 0);
        chk("R12 status after resume", rd_sel, 3);

        // R10 erase accept window
        erase_window = 1'b1;
        wr(22'h20000, 16'h0030);
        chk("R10 window sect_go", sect_go, 1);
        chk("R10 window addr", sect_addr, 22'h20000);
        erase_window = 1'b0;
        wr(22'h30000, 16'h0030);
        chk("R10 closed window", sect_go, 0);
        eng_busy = 1'b0; eng_erase = 1'b0;

        // R1 reset clears bypass
        unlock_pair(); wr(22'h555, 16'h0020);
        chk("R1 bypass set before reset", bypass_on, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 bypass cleared by reset", bypass_on, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule